// File: doc/BRIEF.md
# Two-Stage Redundant Binary Adder Row

This block adds two words whose digits are signed bits taking the values −1, 0 or +1. Each digit is held as a sign bit and a magnitude bit, so its value is (−1)^sign × magnitude. A single cell handles one digit position in two steps. The first step adds the two operand digits and may send a positive transfer upward. The second step absorbs the positive transfer arriving from below and may send a negative transfer upward. The cell's output digit is the second step's result minus the negative transfer arriving from below.

No transfer crosses more than one position. The sum digit at any position therefore depends only on the operand digits at that position and at the two positions below it, whatever the word width. A row of `WIDTH` cells forms a carry-free adder for redundant-binary words. The transfers entering the least significant cell and leaving the most significant cell are brought out, so that rows can be chained. The sum digits and the outgoing transfers are registered once.

Top module: `rbadd_row`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output (`s_neg`, `s_mag`, `pos_out`, `neg_out`) becomes 0 at that edge.
- R2: Define the value of a word as the sum over i of (−1)^neg[i] × mag[i] × 2^i, with bit i of each vector being digit position i. One edge after the inputs are applied, the outputs satisfy value(s) + (pos_out − neg_out) × 2^WIDTH = value(a) + value(b) + pos_in − neg_in.
- R3: An output digit never carries sign 1 with magnitude 0: a zero sum digit is always emitted with `s_neg` = 0.
- R4: An operand digit with sign 1 and magnitude 0 is taken as zero. Replacing every digit of `a` by this negative zero gives exactly the same registered outputs as a plain zero word.
- R5: Sum digit i, and the outgoing transfers, depend only on operand positions i, i−1 and i−2. With WIDTH = 4, changing operand position 0 leaves output digit 3, `pos_out` and `neg_out` unchanged.
- R6: The outputs change one rising edge after the inputs. Before that edge they still show the previous result, and after it they show the new one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| a_neg | input | WIDTH | Sign bits of operand a, bit i is position i |
| a_mag | input | WIDTH | Magnitude bits of operand a |
| b_neg | input | WIDTH | Sign bits of operand b |
| b_mag | input | WIDTH | Magnitude bits of operand b |
| pos_in | input | 1 | Positive transfer into position 0 (weight +1) |
| neg_in | input | 1 | Negative transfer into position 0 (weight −1) |
| s_neg | output | WIDTH | Registered sign bits of the sum |
| s_mag | output | WIDTH | Registered magnitude bits of the sum |
| pos_out | output | 1 | Registered positive transfer out of the top position (weight +2^WIDTH) |
| neg_out | output | 1 | Registered negative transfer out of the top position (weight −2^WIDTH) |

## Verification
Within one cell, two corrections can meet at the output in the same cycle. One is the positive transfer absorbed in the second step. The other is the negative transfer subtracted from its result. This happens at position 0 whenever `pos_in` and `neg_in` are both high, and at higher positions whenever the two lower cells both emit. The sweep covers every operand `a` code, negative zero included, against every trit pattern of `b` under all four combinations of the incoming transfers. Each result is judged by its integer value and by the absence of negative-zero output digits.

// File: rtl/rbadd_pkg.sv
package rbadd_pkg;

    // One signed bit: value = (-1)^neg * mag
    typedef struct packed {
        logic neg;
        logic mag;
    } sdigit_t;

    // Integer value of a sign/magnitude digit word of width w
    function automatic int word_val(input logic [31:0] n, input logic [31:0] m, input int w);
        int v;
        v = 0;
        for (int i = 0; i < 32; i++) begin
            if (i < w && m[i]) begin
                v = n[i] ? v - (1 << i) : v + (1 << i);
            end
        end
        return v;
    endfunction

endpackage

// File: rtl/rbadd_split.sv
module rbadd_split
    import rbadd_pkg::*;
(
    input  sdigit_t dig,
    output logic    pos,
    output logic    neg
);
    // negative zero yields no part on either rail
    assign pos = dig.mag & ~dig.neg;
    assign neg = dig.mag &  dig.neg;
endmodule

// File: rtl/rbadd_sub_stage.sv
module rbadd_sub_stage (
    input  logic       ap,
    input  logic       an,
    input  logic       bp,
    input  logic       bn,
    output logic       tp_out,
    output logic [1:0] w_mag
);
    // interim w is in {-2..0}; w_mag carries -w
    logic signed [3:0] s;
    logic signed [3:0] wv;

    always_comb begin
        s = $signed({3'b000, ap}) + $signed({3'b000, bp})
          - $signed({3'b000, an}) - $signed({3'b000, bn});
        if (s >= 4'sd1) begin
            tp_out = 1'b1;
            wv     = s - 4'sd2;
        end else begin
            tp_out = 1'b0;
            wv     = s;
        end
        w_mag = 2'(-wv);
    end
endmodule

// File: rtl/rbadd_add_stage.sv
module rbadd_add_stage
    import rbadd_pkg::*;
(
    input  logic [1:0] w_mag,
    input  logic       tp_in,
    input  logic       tn_in,
    output logic       tn_out,
    output sdigit_t    sum_dig
);
    logic signed [3:0] z;
    logic signed [3:0] dv;
    logic              dbit;

    always_comb begin
        z = $signed({3'b000, tp_in}) - $signed({2'b00, w_mag});
        if (z < 4'sd0) begin
            tn_out = 1'b1;
            dv     = z + 4'sd2;
        end else begin
            tn_out = 1'b0;
            dv     = z;
        end
        dbit = dv[0];
        // result = dbit - tn_in, zero always with sign 0
        sum_dig.mag = dbit ^ tn_in;
        sum_dig.neg = ~dbit & tn_in;
    end
endmodule

// File: rtl/rbadd_cell.sv
module rbadd_cell
    import rbadd_pkg::*;
(
    input  sdigit_t a_dig,
    input  sdigit_t b_dig,
    input  logic    pos_in,
    input  logic    neg_in,
    output logic    pos_out,
    output logic    neg_out,
    output sdigit_t sum_dig
);
    logic       ap, an, bp, bn;
    logic [1:0] w_mag;

    rbadd_split u_split_a (.dig(a_dig), .pos(ap), .neg(an));
    rbadd_split u_split_b (.dig(b_dig), .pos(bp), .neg(bn));

    rbadd_sub_stage u_sub (
        .ap(ap), .an(an), .bp(bp), .bn(bn),
        .tp_out(pos_out), .w_mag(w_mag)
    );

    rbadd_add_stage u_add (
        .w_mag(w_mag), .tp_in(pos_in), .tn_in(neg_in),
        .tn_out(neg_out), .sum_dig(sum_dig)
    );
endmodule

// File: rtl/rbadd_row.sv
module rbadd_row
    import rbadd_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_neg,
    input  logic [WIDTH-1:0] a_mag,
    input  logic [WIDTH-1:0] b_neg,
    input  logic [WIDTH-1:0] b_mag,
    input  logic             pos_in,
    input  logic             neg_in,
    output logic [WIDTH-1:0] s_neg,
    output logic [WIDTH-1:0] s_mag,
    output logic             pos_out,
    output logic             neg_out
);
    localparam int CHAIN = WIDTH + 1;

    logic [CHAIN-1:0] pchain;
    logic [CHAIN-1:0] nchain;
    logic [WIDTH-1:0] sum_neg;
    logic [WIDTH-1:0] sum_mag;

    assign pchain[0] = pos_in;
    assign nchain[0] = neg_in;

    for (genvar g = 0; g < WIDTH; g++) begin : g_cell
        sdigit_t a_d, b_d, s_d;
        assign a_d = '{neg: a_neg[g], mag: a_mag[g]};
        assign b_d = '{neg: b_neg[g], mag: b_mag[g]};

        rbadd_cell u_cell (
            .a_dig(a_d), .b_dig(b_d),
            .pos_in(pchain[g]), .neg_in(nchain[g]),
            .pos_out(pchain[g+1]), .neg_out(nchain[g+1]),
            .sum_dig(s_d)
        );

        assign sum_neg[g] = s_d.neg;
        assign sum_mag[g] = s_d.mag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_neg   <= '0;
            s_mag   <= '0;
            pos_out <= 1'b0;
            neg_out <= 1'b0;
        end else begin
            s_neg   <= sum_neg;
            s_mag   <= sum_mag;
            pos_out <= pchain[WIDTH];
            neg_out <= nchain[WIDTH];
        end
    end
endmodule

// File: rtl/rbadd_row_chk.sv
module rbadd_row_chk
    import rbadd_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] a_neg,
    input logic [WIDTH-1:0] a_mag,
    input logic [WIDTH-1:0] b_neg,
    input logic [WIDTH-1:0] b_mag,
    input logic             pos_in,
    input logic             neg_in,
    input logic [WIDTH-1:0] s_neg,
    input logic [WIDTH-1:0] s_mag,
    input logic             pos_out,
    input logic             neg_out
);
    localparam int TOPW = 1 << WIDTH;

    // R1: reset clears every output
    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> (s_neg == '0 && s_mag == '0 && !pos_out && !neg_out));

    // R2: registered value equals the arithmetic sum of the previous inputs
    a_r2_value_kept: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |->
        (word_val(32'(s_neg), 32'(s_mag), WIDTH)
            + (int'(pos_out) - int'(neg_out)) * TOPW)
        == $past(word_val(32'(a_neg), 32'(a_mag), WIDTH)
            + word_val(32'(b_neg), 32'(b_mag), WIDTH)
            + int'(pos_in) - int'(neg_in)));

    // R3: no negative zero on the output
    a_r3_no_neg_zero: assert property (@(posedge clk) disable iff (rst)
        (s_neg & ~s_mag) == '0);

    // R6: inputs held steady for a cycle give steady outputs on the next edge
    a_r6_one_edge: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $stable({a_neg, a_mag, b_neg, b_mag, pos_in, neg_in}))
        |=> $stable({s_neg, s_mag, pos_out, neg_out}));
endmodule

bind rbadd_row rbadd_row_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/rbadd_row_bench.sv
module rbadd_row_bench;
    localparam int W = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [W-1:0] an = '0, am = '0, bn = '0, bm = '0;
    logic         pi = 1'b0, ni = 1'b0;
    logic [W-1:0] sn, sm;
    logic         po, no;

    int total = 0;
    int bad   = 0;

    rbadd_row #(.WIDTH(W)) u_rbadd_row (
        .clk(clk), .rst(rst),
        .a_neg(an), .a_mag(am), .b_neg(bn), .b_mag(bm),
        .pos_in(pi), .neg_in(ni),
        .s_neg(sn), .s_mag(sm), .pos_out(po), .neg_out(no)
    );

    function automatic int dval(logic [W-1:0] n, logic [W-1:0] m);
        int v = 0;
        for (int i = 0; i < W; i++)
            if (m[i]) v += n[i] ? -(1 << i) : (1 << i);
        return v;
    endfunction

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_b_trits(int code);
        int r = code;
        for (int i = 0; i < W; i++) begin
            int t = r % 3;
            r = r / 3;
            bn[i] = (t == 0);
            bm[i] = (t != 1);
        end
    endtask

    initial begin
        #3_000_000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [2*W+1:0] ref_vec;
        logic [2:0]     ref_top;

        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 reset outputs", int'({sn, sm, po, no}), 0);
        rst = 1'b0;

        // R6: latency of one edge
        @(negedge clk);
        am = 4'b0001;
        #1 check("R6 before edge", dval(sn, sm), 0);
        @(negedge clk);
        check("R6 after edge", dval(sn, sm), 1);

        // R2 / R3: full sweep, negative zero codes included in a
        for (int ac = 0; ac < 256; ac++) begin
            for (int bt = 0; bt < 81; bt++) begin
                for (int tr = 0; tr < 4; tr++) begin
                    logic [7:0] code = 8'(ac);
                    int exp;
                    an = code[3:0];
                    am = code[7:4];
                    set_b_trits(bt);
                    pi = tr[0];
                    ni = tr[1];
                    exp = dval(an, am) + dval(bn, bm) + int'(pi) - int'(ni);
                    @(negedge clk);
                    check("R2 sum value",
                          dval(sn, sm) + (int'(po) - int'(no)) * (1 << W), exp);
                    check("R3 negative zero output", int'(sn & ~sm), 0);
                end
            end
        end

        // R4: negative zero operand equals plain zero
        for (int bt = 0; bt < 81; bt += 10) begin
            set_b_trits(bt);
            pi = 1'b1; ni = 1'b0;
            an = '1; am = '0;
            @(negedge clk);
            ref_vec = {sn, sm, po, no};
            an = '0; am = '0;
            @(negedge clk);
            check("R4 negative zero operand", int'({sn, sm, po, no}), int'(ref_vec));
        end

        // R5: position 0 inputs do not reach digit 3 or the transfers out
        for (int bt = 0; bt < 27; bt++) begin
            set_b_trits(bt * 3);
            an = 4'b0000; am = 4'b1110;
            bn[0] = 1'b0; bm[0] = 1'b0;
            pi = 1'b0; ni = 1'b0;
            @(negedge clk);
            ref_top = {sn[3] ^ sm[3], po, no};
            ref_top[2] = sm[3];
            ref_vec = '0;
            ref_vec[1:0] = {sn[3], sm[3]};
            an[0] = 1'b1; am[0] = 1'b1;
            bn[0] = 1'b1; bm[0] = 1'b1;
            ni = 1'b1;
            @(negedge clk);
            check("R5 locality digit 3", int'({sn[3], sm[3]}), int'(ref_vec[1:0]));
            check("R5 locality transfers", int'({po, no}), int'(ref_top[1:0]));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule